// File: doc/BRIEF.md
# Amplifier Gain Trim Calibrator

This controller sets the gain of an analog time amplifier through a 16-bit thermometer trim code. Each set bit switches in one small trim current source beside a fixed main source, so more ones mean more gain. Once per reference cycle the controller receives two counter samples: one taken on the retimed reference and one taken on the amplifier output. Their difference, modulo the counter size, is the raw measurement, and its spread across many cycles shows the amplifier's effective gain.

The controller groups valid samples into observation windows of programmable length. For each window it tracks the smallest and largest difference and takes their distance as the swing. At the end of a window it compares the swing with a programmable limit. If the swing is too large, the trim code drops by one thermometer step and a new window begins. If the swing fits, the code freezes and a done flag rises. The code starts at all ones and can only go down. If it reaches all zeros it also freezes with done raised. The controller runs alongside loop acquisition. A synchronous restart re-arms the search.

Top module: `gain_trim_cal`

## Requirements
- R1: After reset the trim code is all ones (16'hFFFF) and done is low.
- R2: Each valid sample's measurement is (reference sample minus amplifier sample) modulo 128, with both samples 7 bits wide.
- R3: The swing of a window is the maximum minus the minimum of the measurements taken in that window only. Samples from earlier windows never contribute.
- R4: A decision is taken only on the valid sample that completes a window of `win_len_i` valid samples. A window length of 0 acts as 1. The code does not change before that sample.
- R5: When a window's swing is greater than `swing_lim_i`, the code drops by exactly one step: its highest set bit clears, and the set bits stay contiguous from bit 0.
- R6: When a window's swing is less than or equal to `swing_lim_i`, done rises and the code holds. While done is high, later samples do not change the code.
- R7: When a step-down leaves the code all zeros, done rises in the same cycle and the code stays zero.
- R8: `restart_i` returns the code to all ones, clears done, and discards any partly gathered window.
- R9: Samples presented with `smp_vld_i` low do not advance the window and do not enter the swing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Synchronous restart of the search |
| smp_vld_i | input | 1 | A new sample pair is present |
| cnt_ref_i | input | 7 | Counter sampled on the retimed reference |
| cnt_amp_i | input | 7 | Counter sampled on the amplifier output |
| win_len_i | input | 8 | Number of valid samples per observation window |
| swing_lim_i | input | 7 | Largest swing accepted as in range |
| therm_o | output | 16 | Thermometer trim code |
| done_o | output | 1 | Code has converged or saturated |

## Verification
The main sweep models an amplifier whose swing is four times the number of set trim bits. It steps the limit from 0 to 64 in steps of 4, so each run should stop at a different code, or run all the way to all zeros, and every window's result is compared. Directed windows whose differences cross the counter wrap separate a modular difference from a signed one. A small-spread window after a wide one shows whether the trackers are cleared. Invalid samples with extreme values, checks part way through a window, a zero window length, and a restart in the middle of a window each test one rule about when a decision may happen.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_LOWER = 2'd1,
    DEC_HOLD  = 2'd2
  } gcal_dec_e;
endpackage

// File: rtl/gcal_diff.sv
module gcal_diff #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] amp_i,
  output logic [CNT_W-1:0] diff_o
);
  // wraps modulo 2**CNT_W by width
  assign diff_o = ref_i - amp_i;
endmodule

// File: rtl/gcal_window.sv
module gcal_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             first_o,
  output logic             last_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] end_idx;

  assign end_idx = (len_i == '0) ? '0 : len_i - WIN_W'(1);
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q >= end_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (adv_i)    cnt_q <= last_o ? '0 : cnt_q + WIN_W'(1);
  end
endmodule

// File: rtl/gcal_swing.sv
module gcal_swing #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             first_i,
  input  logic [CNT_W-1:0] smp_i,
  output logic [CNT_W-1:0] swing_o
);
  logic [CNT_W-1:0] min_q, max_q, min_d, max_d;

  always_comb begin
    if (first_i) begin
      min_d = smp_i;
      max_d = smp_i;
    end else begin
      min_d = (smp_i < min_q) ? smp_i : min_q;
      max_d = (smp_i > max_q) ? smp_i : max_q;
    end
  end

  // swing including the current sample
  assign swing_o = max_d - min_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '0;
      max_q <= '0;
    end else if (vld_i) begin
      min_q <= min_d;
      max_q <= max_d;
    end
  end
endmodule

// File: rtl/gcal_therm.sv
module gcal_therm
  import gcal_pkg::*;
#(
  parameter int THERM_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  gcal_dec_e          dec_i,
  output logic [THERM_W-1:0] code_o,
  output logic               done_o
);
  logic [THERM_W-1:0] code_q, lowered;

  // shift down one step: bit i takes bit i+1, top bit empties
  for (genvar i = 0; i < THERM_W; i++) begin : g_step
    if (i == THERM_W - 1) begin : g_top
      assign lowered[i] = 1'b0;
    end else begin : g_mid
      assign lowered[i] = code_q[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '1;
      done_o <= 1'b0;
    end else if (restart_i) begin
      code_q <= '1;
      done_o <= 1'b0;
    end else if (!done_o) begin
      case (dec_i)
        DEC_LOWER: begin
          code_q <= lowered;
          done_o <= (lowered == '0);
        end
        DEC_HOLD: done_o <= 1'b1;
        default: ;
      endcase
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/gain_trim_cal.sv
module gain_trim_cal
  import gcal_pkg::*;
#(
  parameter int THERM_W = 16,
  parameter int CNT_W   = 7,
  parameter int WIN_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               smp_vld_i,
  input  logic [CNT_W-1:0]   cnt_ref_i,
  input  logic [CNT_W-1:0]   cnt_amp_i,
  input  logic [WIN_W-1:0]   win_len_i,
  input  logic [CNT_W-1:0]   swing_lim_i,
  output logic [THERM_W-1:0] therm_o,
  output logic               done_o
);
  logic             active, win_first, win_last;
  logic [CNT_W-1:0] diff, swing;
  gcal_dec_e        dec;

  assign active = smp_vld_i & ~done_o & ~restart_i;

  gcal_diff #(.CNT_W(CNT_W)) u_diff (
    .ref_i  (cnt_ref_i),
    .amp_i  (cnt_amp_i),
    .diff_o (diff)
  );

  gcal_window #(.WIN_W(WIN_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart_i),
    .adv_i   (active),
    .len_i   (win_len_i),
    .first_o (win_first),
    .last_o  (win_last)
  );

  gcal_swing #(.CNT_W(CNT_W)) u_swing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (active),
    .first_i (win_first),
    .smp_i   (diff),
    .swing_o (swing)
  );

  always_comb begin
    dec = DEC_NONE;
    if (active && win_last) dec = (swing > swing_lim_i) ? DEC_LOWER : DEC_HOLD;
  end

  gcal_therm #(.THERM_W(THERM_W)) u_therm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .dec_i     (dec),
    .code_o    (therm_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/gcal_chk.sv
module gcal_chk #(
  parameter int THERM_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               restart_i,
  input logic [THERM_W-1:0] therm_o,
  input logic               done_o
);
  // R8
  restart_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (therm_o == '1) && !done_o);

  // R5
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(restart_i) && therm_o != $past(therm_o)) |-> therm_o == ($past(therm_o) >> 1));

  // R5
  therm_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o + THERM_W'(1)) & therm_o) == '0);

  // R6
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> done_o && $stable(therm_o));

  // R7
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o == '0) |-> done_o);
endmodule

bind gain_trim_cal gcal_chk #(.THERM_W(THERM_W)) u_gcal_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .therm_o   (therm_o),
  .done_o    (done_o)
);

// File: tb/tb_gain_trim_cal.sv
module tb_gain_trim_cal;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart_i = 1'b0;
  logic        smp_vld_i = 1'b0;
  logic [6:0]  cnt_ref_i = '0;
  logic [6:0]  cnt_amp_i = '0;
  logic [7:0]  win_len_i = 8'd32;
  logic [6:0]  swing_lim_i = 7'd32;
  logic [15:0] therm_o;
  logic        done_o;

  int errs = 0;
  int checks = 0;
  int exp_k = 16;
  bit exp_done = 1'b0;
  int lim = 32;

  always #4 clk_i = ~clk_i;

  gain_trim_cal dut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_therm();
    return (1 << exp_k) - 1;
  endfunction

  task automatic drv(bit v, int r, int a);
    smp_vld_i = v;
    cnt_ref_i = 7'(r);
    cnt_amp_i = 7'(a);
    @(negedge clk_i);
    smp_vld_i = 1'b0;
  endtask

  task automatic model(int sw);
    if (!exp_done) begin
      if (sw <= lim) exp_done = 1'b1;
      else begin
        exp_k--;
        if (exp_k == 0) exp_done = 1'b1;
      end
    end
  endtask

  // window of n valid samples with differences spanning lo..hi
  task automatic run_win(int n, int lo, int hi, int base);
    for (int i = 0; i < n; i++) begin
      int d, a;
      d = (i == 0) ? lo : (i == 1) ? hi : lo + (i % (hi - lo + 1));
      a = (base + i * 37) % 128;
      drv(1'b1, (a + d) % 128, a);
    end
    model(hi - lo);
  endtask

  task automatic restart(int wl, int lm);
    win_len_i = 8'(wl);
    swing_lim_i = 7'(lm);
    lim = lm;
    restart_i = 1'b1;
    @(negedge clk_i);
    restart_i = 1'b0;
    exp_k = 16;
    exp_done = 1'b0;
  endtask

  task automatic chk_state(string tag);
    chk(therm_o == 16'(exp_therm()), tag, int'(therm_o), exp_therm());
    chk(done_o == exp_done, tag, int'(done_o), int'(exp_done));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(therm_o == 16'hFFFF, "R1 code", int'(therm_o), 16'hFFFF);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep limits; stand-in swing = 4 * number of set trim bits (R5 R6 R7)
    for (int t = 0; t <= 64; t += 4) begin
      restart(8, t);
      chk_state("R8 rearm");
      for (int w = 0; w < 20; w++) begin
        run_win(8, 3, 3 + 4 * exp_k, w * 11 + t);
        chk_state("R5/R6/R7 sweep");
      end
    end

    // R6: frozen after done, wide windows ignored
    restart(4, 10);
    run_win(4, 0, 5, 90);
    chk_state("R6 converge");
    run_win(4, 0, 120, 7);
    chk(therm_o == 16'hFFFF && done_o, "R6 frozen", int'(therm_o), 16'hFFFF);

    // R4: no change before window end, then one step
    restart(4, 10);
    for (int i = 0; i < 3; i++) drv(1'b1, (i * 60) % 128, 0);
    chk(therm_o == 16'hFFFF, "R4 mid-window", int'(therm_o), 16'hFFFF);
    drv(1'b1, 5, 0);
    chk(therm_o == 16'h7FFF, "R4 window end", int'(therm_o), 16'h7FFF);

    // R4: length 0 acts as 1
    restart(0, 10);
    drv(1'b1, 50, 20);
    chk(done_o && therm_o == 16'hFFFF, "R4 len0", int'(therm_o), 16'hFFFF);

    // R2: modular difference across counter wrap
    restart(2, 10);
    drv(1'b1, 0, 1);
    drv(1'b1, 10, 10);
    chk(therm_o == 16'h7FFF && !done_o, "R2 wrap 127", int'(therm_o), 16'h7FFF);
    drv(1'b1, 2, 126);
    drv(1'b1, 9, 9);
    chk(therm_o == 16'h7FFF && done_o, "R2 wrap 4", int'(therm_o), 16'h7FFF);

    // R3: trackers cleared per window
    restart(4, 10);
    run_win(4, 0, 50, 3);
    chk_state("R3 first window");
    run_win(4, 60, 62, 40);
    chk_state("R3 second window");

    // R9: invalid samples ignored
    restart(4, 10);
    for (int i = 0; i < 3; i++) drv(1'b1, 20 + i, i);
    drv(1'b0, 100, 0);
    chk(therm_o == 16'hFFFF && !done_o, "R9 invalid", int'(therm_o), 16'hFFFF);
    drv(1'b1, 30, 10);
    chk(therm_o == 16'hFFFF && done_o, "R9 window", int'(done_o), 1);

    // R8: restart mid-window discards partial samples
    restart(4, 10);
    drv(1'b1, 0, 0);
    drv(1'b1, 100, 0);
    restart(4, 10);
    for (int i = 0; i < 4; i++) drv(1'b1, 40, 35);
    chk(therm_o == 16'hFFFF && done_o, "R8 discard", int'(therm_o), 16'hFFFF);

    // R7: saturation at zero
    restart(2, 0);
    for (int w = 0; w < 16; w++) begin
      run_win(2, 0, 1, w);
      chk_state("R7 walk");
    end
    chk(therm_o == 16'h0 && done_o, "R7 saturate", int'(therm_o), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule